// File: doc/BRIEF.md
# Processor Power Mode Sequencer

This block steps a processor through five operating modes that trade performance against power: Full-On, Active, Sleep, Deep Sleep and Hibernate. From its current mode it drives the core clock enable, the system clock enable, the PLL enable, the PLL bypass select, the core regulator enable and a tri-state control for the external pins. It also reports whether system DMA may reach L1 memory.

Software moves the block by writing PLL settings (bypass bit, enable bit, multiplier), by writing the regulator frequency field, and by issuing mode requests. A wakeup event ends Sleep. The reset pin ends Deep Sleep and Hibernate. The saved bypass bit decides whether the processor comes back in Full-On or in Active. PLL lock and regulator settling are modelled as a lock wait of programmable length. The core clock stays gated for that whole wait.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset the mode output is 0 (Full-On), busy is low, the bypass bit is clear, the PLL is enabled and the effective multiplier equals the MULT_RST parameter.
- R2: The outputs follow the mode code (0 Full-On, 1 Active, 2 Sleep, 3 Deep Sleep, 4 Hibernate, 5 lock wait).
  - Core clock and DMA-to-L1 permission are on only in codes 0 and 1.
  - The system clock is on in codes 0, 1, 2 and 5.
  - The regulator is off and the pins are tri-stated only in code 4.
  - The PLL is on in 0, 2 and 5, follows the saved enable bit in 1, and is off in 3 and 4.
  - Bypass is set in 1 and 5. In 2 it is set only if Sleep was entered from Active. It is clear in every other code.
- R3: A PLL control write that clears the enable bit is accepted only in Active. While the PLL is disabled, requests for Full-On (req_mode 0) and for Sleep (req_mode 2) are refused, and the mode does not change.
- R4: A Full-On request from Active enters the lock wait (code 5, busy high) for lock_cycles+1 cycles and then enters Full-On. A multiplier written earlier becomes visible on mult_eff only when Full-On is entered.
- R5: A Full-On request clears the bypass bit and an Active request (req_mode 1) sets it. On a wakeup in Sleep, the block goes to Active if the bypass bit is set and to Full-On if it is clear.
- R6: In Deep Sleep (entered by req_mode 3) a wakeup is ignored. The reset pin leaves Deep Sleep: to Active if the bypass bit is set, otherwise through the lock wait into Full-On.
- R7: From Full-On or Active, a regulator write of code 0 enters Hibernate, even if a mode request arrives in the same cycle. A non-zero code has no effect.
- R8: In Hibernate, wakeups and requests are ignored. Only the reset pin leaves it. The exit goes through the lock wait into Full-On, with the bypass bit cleared and the PLL enabled.
- R9: Mode requests during the lock wait are dropped. The reset pin has no effect in Full-On, Active or Sleep.
- R10: A PLL control write and a mode request in the same cycle are handled as if the write came first. The request is judged against the newly written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Reset pin event, used to exit Deep Sleep and Hibernate |
| wake | input | 1 | Wakeup event |
| cfg_wr | input | 1 | PLL control write strobe |
| cfg_bypass | input | 1 | Bypass bit written by cfg_wr |
| cfg_pll_en | input | 1 | PLL enable bit written by cfg_wr |
| cfg_mult | input | MULT_W | Multiplier written by cfg_wr |
| vr_wr | input | 1 | Regulator control write strobe |
| vr_freq | input | VR_W | Regulator frequency field, 0 requests Hibernate |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 0 Full-On, 1 Active, 2 Sleep, 3 Deep Sleep |
| lock_cycles | input | LOCK_W | Lock wait length minus one |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| pll_en | output | 1 | PLL enable |
| pll_bypass | output | 1 | PLL bypass select |
| vreg_en | output | 1 | Core regulator enable |
| io_tristate | output | 1 | Tri-state external pins |
| dma_l1_ok | output | 1 | System DMA may access L1 |
| mode | output | 3 | Current mode code |
| busy | output | 1 | Lock wait in progress |
| mult_eff | output | MULT_W | Multiplier in effect |

## Verification
Two events can land in the same cycle here.

The first pair is a PLL control write and a mode request. Both are driven in Active with the enable bit going from 0 to 1 and a Full-On request. The verdict is that the block enters the lock wait at once instead of refusing the request.

The second pair is a regulator write of code 0 and an Active request. Both are driven in Full-On, and the bench expects Hibernate to win. The mode code is sampled on the falling edge after the clock edge that takes both events in.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        M_FULL  = 3'd0,
        M_ACT   = 3'd1,
        M_SLEEP = 3'd2,
        M_DEEP  = 3'd3,
        M_HIBER = 3'd4,
        M_LOCK  = 3'd5
    } pmode_e;

    typedef struct packed {
        logic cclk;
        logic sclk;
        logic pll;
        logic byp;
        logic vreg;
        logic tri_io;
        logic dma;
    } pout_t;

endpackage

// File: rtl/pmc_cfg.sv
module pmc_cfg #(
    parameter int MULT_W = 6
) (
    input  pmc_pkg::pmode_e    state,
    input  logic               cfg_wr,
    input  logic               cfg_bypass,
    input  logic               cfg_pll_en,
    input  logic [MULT_W-1:0]  cfg_mult,
    input  logic               byp_q,
    input  logic               pll_q,
    input  logic [MULT_W-1:0]  pend_q,
    output logic               byp_w,
    output logic               pll_w,
    output logic [MULT_W-1:0]  pend_w
);
    import pmc_pkg::*;

    logic running;

    always_comb begin
        running = (state == M_FULL) || (state == M_ACT);
        byp_w   = byp_q;
        pll_w   = pll_q;
        pend_w  = pend_q;
        if (cfg_wr && running) begin
            byp_w  = cfg_bypass;
            pend_w = cfg_mult;
            // the PLL may only be switched off while bypassed in Active
            if (cfg_pll_en || state == M_ACT) begin
                pll_w = cfg_pll_en;
            end
        end
    end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm #(
    parameter int LOCK_W = 10,
    parameter int VR_W   = 2
) (
    input  pmc_pkg::pmode_e    state,
    input  logic               byp_w,
    input  logic               pll_w,
    input  logic               vr_wr,
    input  logic [VR_W-1:0]    vr_freq,
    input  logic               req_valid,
    input  logic [1:0]         req_mode,
    input  logic               wake,
    input  logic               rst_pin,
    input  logic [LOCK_W-1:0]  lock_cycles,
    input  logic [LOCK_W-1:0]  cnt_q,
    output pmc_pkg::pmode_e    state_n,
    output logic [LOCK_W-1:0]  cnt_n,
    output logic               byp_set,
    output logic               byp_clr,
    output logic               pll_set
);
    import pmc_pkg::*;

    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        byp_set = 1'b0;
        byp_clr = 1'b0;
        pll_set = 1'b0;
        unique case (state)
            M_FULL, M_ACT: begin
                if (vr_wr && vr_freq == '0) begin
                    state_n = M_HIBER;
                end else if (req_valid) begin
                    unique case (req_mode)
                        2'd0: begin
                            if (pll_w) begin
                                byp_clr = 1'b1;
                                if (state == M_ACT) begin
                                    state_n = M_LOCK;
                                    cnt_n   = lock_cycles;
                                end
                            end
                        end
                        2'd1: begin
                            byp_set = 1'b1;
                            state_n = M_ACT;
                        end
                        2'd2: begin
                            if (pll_w) state_n = M_SLEEP;
                        end
                        default: state_n = M_DEEP;
                    endcase
                end
            end
            M_SLEEP: begin
                if (wake) state_n = byp_w ? M_ACT : M_FULL;
            end
            M_DEEP: begin
                if (rst_pin) begin
                    if (byp_w) begin
                        state_n = M_ACT;
                    end else begin
                        state_n = M_LOCK;
                        cnt_n   = lock_cycles;
                        pll_set = 1'b1;
                    end
                end
            end
            M_HIBER: begin
                if (rst_pin) begin
                    state_n = M_LOCK;
                    cnt_n   = lock_cycles;
                    byp_clr = 1'b1;
                    pll_set = 1'b1;
                end
            end
            default: begin
                if (cnt_q == '0) state_n = M_FULL;
                else             cnt_n   = cnt_q - 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pmc_out.sv
module pmc_out (
    input  pmc_pkg::pmode_e state,
    input  logic            pll_q,
    input  logic            slpbyp_q,
    output pmc_pkg::pout_t  o
);
    import pmc_pkg::*;

    always_comb begin
        o = '0;
        unique case (state)
            M_FULL:  o = '{cclk:1'b1, sclk:1'b1, pll:1'b1,  byp:1'b0,     vreg:1'b1, tri_io:1'b0, dma:1'b1};
            M_ACT:   o = '{cclk:1'b1, sclk:1'b1, pll:pll_q, byp:1'b1,     vreg:1'b1, tri_io:1'b0, dma:1'b1};
            M_SLEEP: o = '{cclk:1'b0, sclk:1'b1, pll:1'b1,  byp:slpbyp_q, vreg:1'b1, tri_io:1'b0, dma:1'b0};
            M_DEEP:  o = '{cclk:1'b0, sclk:1'b0, pll:1'b0,  byp:1'b0,     vreg:1'b1, tri_io:1'b0, dma:1'b0};
            M_HIBER: o = '{cclk:1'b0, sclk:1'b0, pll:1'b0,  byp:1'b0,     vreg:1'b0, tri_io:1'b1, dma:1'b0};
            default: o = '{cclk:1'b0, sclk:1'b1, pll:1'b1,  byp:1'b1,     vreg:1'b1, tri_io:1'b0, dma:1'b0};
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int MULT_W   = 6,
    parameter int LOCK_W   = 10,
    parameter int VR_W     = 2,
    parameter int MULT_RST = 10
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              wake,
    input  logic              cfg_wr,
    input  logic              cfg_bypass,
    input  logic              cfg_pll_en,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic              vr_wr,
    input  logic [VR_W-1:0]   vr_freq,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [LOCK_W-1:0] lock_cycles,
    output logic              cclk_en,
    output logic              sclk_en,
    output logic              pll_en,
    output logic              pll_bypass,
    output logic              vreg_en,
    output logic              io_tristate,
    output logic              dma_l1_ok,
    output logic [2:0]        mode,
    output logic              busy,
    output logic [MULT_W-1:0] mult_eff
);
    import pmc_pkg::*;

    localparam logic [MULT_W-1:0] MULT_INIT = MULT_W'(MULT_RST);

    typedef struct packed {
        pmode_e              state;
        logic [LOCK_W-1:0]   cnt;
        logic                byp;
        logic                pll;
        logic                slpbyp;
        logic [MULT_W-1:0]   pend;
        logic [MULT_W-1:0]   mult;
    } regs_t;

    regs_t r_q, r_d;

    logic              byp_w, pll_w;
    logic [MULT_W-1:0] pend_w;
    pmode_e            state_n;
    logic [LOCK_W-1:0] cnt_n;
    logic              byp_set, byp_clr, pll_set;
    pout_t             o;

    pmc_cfg #(.MULT_W(MULT_W)) i_cfg (
        .state(r_q.state), .cfg_wr(cfg_wr), .cfg_bypass(cfg_bypass),
        .cfg_pll_en(cfg_pll_en), .cfg_mult(cfg_mult),
        .byp_q(r_q.byp), .pll_q(r_q.pll), .pend_q(r_q.pend),
        .byp_w(byp_w), .pll_w(pll_w), .pend_w(pend_w)
    );

    pmc_fsm #(.LOCK_W(LOCK_W), .VR_W(VR_W)) i_fsm (
        .state(r_q.state), .byp_w(byp_w), .pll_w(pll_w),
        .vr_wr(vr_wr), .vr_freq(vr_freq), .req_valid(req_valid),
        .req_mode(req_mode), .wake(wake), .rst_pin(rst_pin),
        .lock_cycles(lock_cycles), .cnt_q(r_q.cnt),
        .state_n(state_n), .cnt_n(cnt_n),
        .byp_set(byp_set), .byp_clr(byp_clr), .pll_set(pll_set)
    );

    pmc_out i_out (
        .state(r_q.state), .pll_q(r_q.pll), .slpbyp_q(r_q.slpbyp), .o(o)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = state_n;
        r_d.cnt   = cnt_n;
        r_d.pend  = pend_w;
        r_d.byp   = byp_clr ? 1'b0 : (byp_set ? 1'b1 : byp_w);
        r_d.pll   = pll_set | pll_w;
        if (state_n == M_SLEEP && r_q.state != M_SLEEP) begin
            r_d.slpbyp = (r_q.state == M_ACT);
        end
        if (state_n == M_FULL && r_q.state != M_FULL) begin
            r_d.mult = pend_w;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= '{state:M_FULL, cnt:'0, byp:1'b0, pll:1'b1, slpbyp:1'b0,
                     pend:MULT_INIT, mult:MULT_INIT};
        end else begin
            r_q <= r_d;
        end
    end

    assign cclk_en     = o.cclk;
    assign sclk_en     = o.sclk;
    assign pll_en      = o.pll;
    assign pll_bypass  = o.byp;
    assign vreg_en     = o.vreg;
    assign io_tristate = o.tri_io;
    assign dma_l1_ok   = o.dma;
    assign mode        = r_q.state;
    assign busy        = (r_q.state == M_LOCK);
    assign mult_eff    = r_q.mult;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_pin,
    input logic       cfg_wr,
    input logic       req_valid,
    input logic [1:0] req_mode,
    input logic       cclk_en,
    input logic       pll_en,
    input logic       vreg_en,
    input logic       io_tristate,
    input logic       dma_l1_ok,
    input logic [2:0] mode,
    input logic       busy
);
    a_r2_hiber_pins: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd4) |-> (io_tristate && !vreg_en));

    a_r2_sleep_no_dma: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd2) |-> (!dma_l1_ok && !cclk_en));

    a_r4_lock_core_off: assert property (@(posedge clk) disable iff (!por_n)
        busy |-> !cclk_en);

    a_r3_refuse_full: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd1 && !pll_en && !cfg_wr && req_valid && req_mode == 2'd0) |=> (mode == 3'd1));

    a_r6_deep_hold: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd3 && !rst_pin) |=> (mode == 3'd3));

    a_r8_hiber_hold: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd4 && !rst_pin) |=> (mode == 3'd4));

    a_r9_lock_exit_full: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !$past(busy) && $past(mode) != 3'd5) |-> ($past(mode) != 3'd2));
endmodule

bind pwr_mode_ctrl pmc_checker i_chk (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .cfg_wr(cfg_wr),
    .req_valid(req_valid), .req_mode(req_mode), .cclk_en(cclk_en),
    .pll_en(pll_en), .vreg_en(vreg_en), .io_tristate(io_tristate),
    .dma_l1_ok(dma_l1_ok), .mode(mode), .busy(busy)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int MULT_W = 6;
    localparam int LOCK_W = 10;
    localparam int NV     = 44;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              rst_pin = 0, wake = 0, cfg_wr = 0, cfg_bypass = 0, cfg_pll_en = 0;
    logic [MULT_W-1:0] cfg_mult = 6'd10;
    logic              vr_wr = 0;
    logic [1:0]        vr_freq = 0;
    logic              req_valid = 0;
    logic [1:0]        req_mode = 0;
    logic [LOCK_W-1:0] lock_cycles = 10'd2;
    logic cclk_en, sclk_en, pll_en, pll_bypass, vreg_en, io_tristate, dma_l1_ok, busy;
    logic [2:0]        mode;
    logic [MULT_W-1:0] mult_eff;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wake(wake), .cfg_wr(cfg_wr),
        .cfg_bypass(cfg_bypass), .cfg_pll_en(cfg_pll_en), .cfg_mult(cfg_mult),
        .vr_wr(vr_wr), .vr_freq(vr_freq), .req_valid(req_valid), .req_mode(req_mode),
        .lock_cycles(lock_cycles), .cclk_en(cclk_en), .sclk_en(sclk_en), .pll_en(pll_en),
        .pll_bypass(pll_bypass), .vreg_en(vreg_en), .io_tristate(io_tristate),
        .dma_l1_ok(dma_l1_ok), .mode(mode), .busy(busy), .mult_eff(mult_eff)
    );

    // fields: cfg_wr byp pll_en | vr_wr vr_freq | req_valid req_mode | wake rst_pin | exp_pll exp_mode
    localparam logic [14:0] VEC [NV] = '{
        15'b0_0_0_0_00_1_01_0_0_1_001, // R5 request Active
        15'b1_1_0_0_00_0_00_0_0_0_001, // R3 disable PLL in Active
        15'b0_0_0_0_00_1_00_0_0_0_001, // R3 Full-On refused
        15'b0_0_0_0_00_1_10_0_0_0_001, // R3 Sleep refused
        15'b1_1_1_0_00_1_00_0_0_1_101, // R10 write enable and request together
        15'b0_0_0_0_00_1_11_0_0_1_101, // R9 request dropped in lock wait
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_000, // R4 lock done
        15'b0_0_0_0_00_1_10_0_0_1_010, // Sleep
        15'b0_0_0_0_00_0_00_1_0_1_000, // R5 wake, bypass clear -> Full-On
        15'b0_0_0_0_00_1_11_0_0_0_011, // R6 Deep Sleep
        15'b0_0_0_0_00_0_00_1_0_0_011, // R6 wake ignored
        15'b0_0_0_0_00_0_00_0_1_1_101, // R6 reset pin -> lock wait
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_000,
        15'b0_0_0_0_00_1_01_0_0_1_001, // Active, bypass set
        15'b0_0_0_0_00_1_11_0_0_0_011, // Deep Sleep
        15'b0_0_0_0_00_0_00_0_1_1_001, // R6 reset pin -> Active
        15'b0_0_0_1_00_0_00_0_0_0_100, // R7 Hibernate
        15'b0_0_0_0_00_0_00_1_0_0_100, // R8 wake ignored
        15'b0_0_0_0_00_1_01_0_0_0_100, // R8 request ignored
        15'b0_0_0_0_00_0_00_0_1_1_101, // R8 reset pin -> lock wait
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_000,
        15'b0_0_0_1_01_0_00_0_0_1_000, // R7 non-zero code no effect
        15'b1_0_0_0_00_0_00_0_0_1_000, // R3 disable ignored in Full-On
        15'b0_0_0_0_00_1_10_0_0_1_010, // R3 Sleep accepted, PLL still on
        15'b0_0_0_0_00_0_00_0_1_1_010, // R9 reset pin ignored in Sleep
        15'b0_0_0_0_00_0_00_1_0_1_000,
        15'b0_0_0_0_00_0_00_0_1_1_000, // R9 reset pin ignored in Full-On
        15'b0_0_0_1_00_1_01_0_0_0_100, // R7 Hibernate beats request
        15'b0_0_0_0_00_0_00_0_1_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_000, // R8 back in Full-On
        15'b0_0_0_0_00_1_01_0_0_1_001,
        15'b0_0_0_0_00_1_10_0_0_1_010, // Sleep from Active
        15'b0_0_0_0_00_0_00_1_0_1_001, // R5 wake, bypass set -> Active
        15'b0_0_0_0_00_1_00_0_0_1_101, // R4 lock wait
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_101,
        15'b0_0_0_0_00_0_00_0_0_1_000
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_outs(input logic [2:0] m, input logic ep, input logic sb);
        check("R2 cclk_en", cclk_en, (m == 0 || m == 1));
        check("R2 sclk_en", sclk_en, (m != 3 && m != 4));
        check("R2 pll_en", pll_en, ep);
        check("R2 pll_bypass", pll_bypass, (m == 1 || m == 5 || (m == 2 && sb)));
        check("R2 vreg_en", vreg_en, (m != 4));
        check("R2 io_tristate", io_tristate, (m == 4));
        check("R2 dma_l1_ok", dma_l1_ok, (m == 0 || m == 1));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [2:0] prev;
        logic       sb;
        int         nbusy;
        prev = 3'd0;
        sb = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 busy", busy, 0);
        check("R1 mult_eff", mult_eff, 10);
        check_outs(3'd0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            cfg_wr = v[14]; cfg_bypass = v[13]; cfg_pll_en = v[12];
            vr_wr = v[11]; vr_freq = v[10:9];
            req_valid = v[8]; req_mode = v[7:6];
            wake = v[5]; rst_pin = v[4];
            @(negedge clk);
            cfg_wr = 0; vr_wr = 0; req_valid = 0; wake = 0; rst_pin = 0;
            if (v[2:0] == 3'd2 && prev != 3'd2) sb = (prev == 3'd1);
            check($sformatf("R2..R10 vector %0d mode", i), mode, v[2:0]);
            check_outs(v[2:0], v[3], sb);
            check("R4 busy", busy, (v[2:0] == 3'd5));
            prev = v[2:0];
        end

        // R4 multiplier takes effect only on entering Full-On, after lock_cycles+1
        req_valid = 1; req_mode = 2'd1;
        cfg_wr = 1; cfg_bypass = 1; cfg_pll_en = 1; cfg_mult = 6'd20;
        @(negedge clk);
        req_valid = 0; cfg_wr = 0;
        check("R4 mult held in Active", mult_eff, 10);
        check("R4 mode Active", mode, 1);
        lock_cycles = 10'd4;
        req_valid = 1; req_mode = 2'd0;
        @(negedge clk);
        req_valid = 0;
        nbusy = 0;
        for (int k = 0; k < 20 && mode != 3'd0; k++) begin
            if (busy) nbusy++;
            if (k == 0) check("R4 mult held in lock wait", mult_eff, 10);
            @(negedge clk);
        end
        check("R4 lock wait length", nbusy, 5);
        check("R4 mode Full-On", mode, 0);
        check("R4 mult applied", mult_eff, 20);

        done = 1;
        finish_run();
    end
endmodule